// File: doc/BRIEF.md
# Maskable Interrupt Status Controller

This block gathers eight single-cycle event strobes into a sticky status word and drives one active-low interrupt request line. Each source has a mask bit. A masked source is still captured and held, but it is hidden from status reads and kept off the interrupt line until software clears its mask bit. At that point the held event shows up and can raise the interrupt.

One source, a command/indication channel change flag whose index is a parameter, is treated differently. It always appears in the status word, masked or not. While masked it still cannot pull the interrupt line low.

A host reaches two registers through a one-cycle strobe bus. The status register is read-to-clear: a read removes exactly the bits it returned. The mask register can be read and written. The asynchronous reset is released synchronously inside the block.

Top module: `irq_status_ctrl`

## Requirements
- R1: After reset the mask register reads 0xFF, the status register reads 0x00 and `irq_n_o` is high.
- R2: A pulse on an unmasked source sets its status bit. The next status read returns that bit, and `irq_n_o` is low until the bit is cleared.
- R3: An event on a source whose mask bit is 1 reads as 0 in status and leaves `irq_n_o` high. The channel-change bit is the exception and follows R5.
- R4: An event on a masked source is held. Once its mask bit is written to 0, the bit reads as 1 in status and `irq_n_o` goes low.
- R5: The channel-change source (bit `CC_IDX`, default bit 2) reads as 1 in status after its event, even when masked. While masked it never drives `irq_n_o` low.
- R6: A status read clears only the bits it returned. Held masked events survive the read.
- R7: An event that arrives in the same cycle as a status read is not lost. It is returned by the following read.
- R8: `irq_n_o` is low exactly while some held event has its mask bit at 0. It returns high once all such bits are cleared.
- R9: A write with `addr_i`=1 loads `wdata_i` into the mask register. A read with `addr_i`=1 returns it.
- R10: `rdata_o` is 0 in any cycle without a read strobe (`sel_i`=1, `wr_i`=0). Address 0 selects status and address 1 selects mask.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| evt_i | input | 8 | One-cycle event strobes, one per source |
| sel_i | input | 1 | Bus access strobe, one cycle per access |
| wr_i | input | 1 | 1 = write, 0 = read |
| addr_i | input | 1 | 0 = status, 1 = mask |
| wdata_i | input | 8 | Write data for the mask register |
| rdata_o | output | 8 | Read data, valid in the strobe cycle |
| irq_n_o | output | 1 | Active-low interrupt request |

## Verification
On every cycle, the assertions check four things:
- a status read never exposes a masked ordinary source;
- a masked channel-change flag is always returned;
- held masked events survive, and fresh events are captured even during a read;
- the interrupt line matches the presence of unmasked held events.

Some behaviour only the bench's scenarios can show:
- the reset values;
- the mask write and read-back;
- that a held event surfaces after unmasking;
- that a read clears exactly the returned bits;
- the value returned by the read after a read that collided with an event.

// File: rtl/isc_pkg.sv
package isc_pkg;
  typedef enum logic {
    REG_STATUS = 1'b0,
    REG_MASK   = 1'b1
  } isc_reg_e;
endpackage

// File: rtl/isc_rst_sync.sv
module isc_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [STAGES-1:0] sync_q;
  logic [STAGES-1:0] sync_d;

  always_comb begin
    sync_d = {sync_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= sync_d;
  end

  assign rst_sync_n = sync_q[STAGES-1];
endmodule

// File: rtl/isc_mask_reg.sv
module isc_mask_reg #(
  parameter int N_SRC = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [N_SRC-1:0] wdata,
  output logic [N_SRC-1:0] mask_q
);
  logic [N_SRC-1:0] mask_d;

  always_comb begin
    mask_d = mask_q;
    if (wr_en) mask_d = wdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     mask_q <= '1;
    else if (wr_en) mask_q <= mask_d;
  end
endmodule

// File: rtl/isc_event_latch.sv
module isc_event_latch #(
  parameter int N_SRC = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [N_SRC-1:0] evt,
  input  logic [N_SRC-1:0] clr,
  output logic [N_SRC-1:0] pend_q
);
  for (genvar i = 0; i < N_SRC; i++) begin : g_bit
    logic bit_d;
    logic bit_en;

    always_comb begin
      bit_en = evt[i] | clr[i];
      // a new event wins over a clear in the same cycle
      bit_d  = evt[i] | (pend_q[i] & ~clr[i]);
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      pend_q[i] <= 1'b0;
      else if (bit_en) pend_q[i] <= bit_d;
    end
  end
endmodule

// File: rtl/isc_view.sv
module isc_view #(
  parameter int N_SRC  = 8,
  parameter int CC_IDX = 2
) (
  input  logic [N_SRC-1:0] pend,
  input  logic [N_SRC-1:0] mask,
  output logic [N_SRC-1:0] visible,
  output logic             irq_req
);
  localparam logic [N_SRC-1:0] CC_BIT = N_SRC'(1) << CC_IDX;

  logic [N_SRC-1:0] unmasked;

  always_comb begin
    unmasked = pend & ~mask;
    visible  = unmasked | (pend & CC_BIT);
    irq_req  = |unmasked;
  end
endmodule

// File: rtl/irq_status_ctrl.sv
module irq_status_ctrl #(
  parameter int N_SRC  = 8,
  parameter int CC_IDX = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [N_SRC-1:0] evt_i,
  input  logic             sel_i,
  input  logic             wr_i,
  input  logic             addr_i,
  input  logic [N_SRC-1:0] wdata_i,
  output logic [N_SRC-1:0] rdata_o,
  output logic             irq_n_o
);
  import isc_pkg::*;

  logic             rst_sync_n;
  logic             rd_status;
  logic             rd_mask;
  logic             wr_mask;
  logic [N_SRC-1:0] mask_q;
  logic [N_SRC-1:0] pend_q;
  logic [N_SRC-1:0] visible;
  logic [N_SRC-1:0] clr_vec;
  logic             irq_req;

  isc_rst_sync #(.STAGES(2)) u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  always_comb begin
    rd_status = sel_i & ~wr_i & (isc_reg_e'(addr_i) == REG_STATUS);
    rd_mask   = sel_i & ~wr_i & (isc_reg_e'(addr_i) == REG_MASK);
    wr_mask   = sel_i &  wr_i & (isc_reg_e'(addr_i) == REG_MASK);
    clr_vec   = rd_status ? visible : '0;
  end

  isc_mask_reg #(.N_SRC(N_SRC)) u_mask (
    .clk    (clk),
    .rst_n  (rst_sync_n),
    .wr_en  (wr_mask),
    .wdata  (wdata_i),
    .mask_q (mask_q)
  );

  isc_event_latch #(.N_SRC(N_SRC)) u_latch (
    .clk    (clk),
    .rst_n  (rst_sync_n),
    .evt    (evt_i),
    .clr    (clr_vec),
    .pend_q (pend_q)
  );

  isc_view #(.N_SRC(N_SRC), .CC_IDX(CC_IDX)) u_view (
    .pend    (pend_q),
    .mask    (mask_q),
    .visible (visible),
    .irq_req (irq_req)
  );

  always_comb begin
    rdata_o = '0;
    if (rd_status)    rdata_o = visible;
    else if (rd_mask) rdata_o = mask_q;
    irq_n_o = ~irq_req;
  end
endmodule

// File: rtl/isc_chk.sv
module isc_chk #(
  parameter int N_SRC  = 8,
  parameter int CC_IDX = 2
) (
  input logic             clk,
  input logic             rst_n,
  input logic [N_SRC-1:0] evt_i,
  input logic             rd_status,
  input logic             wr_mask,
  input logic [N_SRC-1:0] mask_q,
  input logic [N_SRC-1:0] pend_q,
  input logic [N_SRC-1:0] rdata_o,
  input logic             irq_n_o
);
  localparam logic [N_SRC-1:0] CC_BIT = N_SRC'(1) << CC_IDX;

  // R3
  hidden_masked_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rd_status |-> ((rdata_o & mask_q & ~CC_BIT) == '0));

  // R5
  cc_visible_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_status && ((pend_q & CC_BIT) != '0)) |-> ((rdata_o & CC_BIT) != '0));

  // R4
  pending_kept_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_mask |=> ((pend_q & $past(pend_q & mask_q & ~CC_BIT)) == $past(pend_q & mask_q & ~CC_BIT)));

  // R7
  evt_captured_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (evt_i != '0) |=> ((pend_q & $past(evt_i)) == $past(evt_i)));

  // R8
  irq_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((pend_q & ~mask_q) == '0) |-> irq_n_o);

  // R8
  irq_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((pend_q & ~mask_q) != '0) |-> !irq_n_o);
endmodule

bind irq_status_ctrl isc_chk #(.N_SRC(N_SRC), .CC_IDX(CC_IDX)) u_chk (
  .clk       (clk),
  .rst_n     (rst_sync_n),
  .evt_i     (evt_i),
  .rd_status (rd_status),
  .wr_mask   (wr_mask),
  .mask_q    (mask_q),
  .pend_q    (pend_q),
  .rdata_o   (rdata_o),
  .irq_n_o   (irq_n_o)
);

// File: tb/tb_irq_status_ctrl.sv
module tb_irq_status_ctrl;
  localparam int N = 8;
  localparam logic [1:0] OP_EVT = 2'd0, OP_WMASK = 2'd1, OP_RSTAT = 2'd2, OP_RMASK = 2'd3;
  // entry: {req[3:0], op[1:0], data[7:0], exp_rdata[7:0], exp_irq_n}
  localparam int NV = 17;
  localparam logic [22:0] VEC [NV] = '{
    {4'd9,  OP_RMASK, 8'h00, 8'hFF, 1'b1}, // R1 R9 reset mask
    {4'd1,  OP_RSTAT, 8'h00, 8'h00, 1'b1}, // R1 reset status
    {4'd9,  OP_WMASK, 8'hF0, 8'h00, 1'b1}, // R9 unmask 0..3
    {4'd2,  OP_EVT,   8'h01, 8'h00, 1'b0}, // R2
    {4'd6,  OP_RSTAT, 8'h00, 8'h01, 1'b1}, // R2 R6 R8
    {4'd3,  OP_EVT,   8'h10, 8'h00, 1'b1}, // R3 masked bit4
    {4'd3,  OP_RSTAT, 8'h00, 8'h00, 1'b1}, // R3
    {4'd4,  OP_WMASK, 8'hE0, 8'h00, 1'b0}, // R4 unmask bit4
    {4'd4,  OP_RSTAT, 8'h00, 8'h10, 1'b1}, // R4
    {4'd9,  OP_WMASK, 8'hFF, 8'h00, 1'b1}, // R9
    {4'd5,  OP_EVT,   8'h04, 8'h00, 1'b1}, // R5 masked cc
    {4'd5,  OP_RSTAT, 8'h00, 8'h04, 1'b1}, // R5
    {4'd6,  OP_RSTAT, 8'h00, 8'h00, 1'b1}, // R6 cleared
    {4'd6,  OP_EVT,   8'h24, 8'h00, 1'b1}, // R6
    {4'd6,  OP_RSTAT, 8'h00, 8'h04, 1'b1}, // R6 bit5 held
    {4'd4,  OP_WMASK, 8'h00, 8'h00, 1'b0}, // R4 bit5 surfaces
    {4'd8,  OP_RSTAT, 8'h00, 8'h20, 1'b1}  // R8 line released
  };

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [N-1:0] evt_i = '0;
  logic sel_i = 1'b0, wr_i = 1'b0, addr_i = 1'b0;
  logic [N-1:0] wdata_i = '0;
  logic [N-1:0] rdata_o;
  logic irq_n_o;
  int n_chk = 0, n_fail = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  irq_status_ctrl #(.N_SRC(N), .CC_IDX(2)) dut (
    .clk(clk), .rst_n(rst_n), .evt_i(evt_i), .sel_i(sel_i), .wr_i(wr_i),
    .addr_i(addr_i), .wdata_i(wdata_i), .rdata_o(rdata_o), .irq_n_o(irq_n_o));

  task automatic check(input string req, input logic [N-1:0] act, input logic [N-1:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // drive at negedge, check rdata before the edge, check irq after it
  task automatic step(input logic [1:0] op, input logic [N-1:0] d, input logic [N-1:0] ev,
                      input logic [N-1:0] exp_rd, input logic exp_irq, input string req);
    @(negedge clk);
    evt_i = ev; wdata_i = d;
    sel_i = (op != OP_EVT); wr_i = (op == OP_WMASK);
    addr_i = (op == OP_WMASK || op == OP_RMASK);
    #1 check(req, rdata_o, exp_rd);
    @(posedge clk); #1;
    evt_i = '0; sel_i = 1'b0; wr_i = 1'b0;
    check(req, {7'd0, irq_n_o}, {7'd0, exp_irq});
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    repeat (2) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;
    repeat (3) @(posedge clk);
  endtask

  initial begin
    do_reset();
    #1 check("R1 irq after reset", {7'd0, irq_n_o}, 8'h01);
    for (int i = 0; i < NV; i++) begin
      logic [22:0] v;
      v = VEC[i];
      step(v[18:17], (v[18:17] == OP_EVT) ? '0 : v[16:9],
           (v[18:17] == OP_EVT) ? v[16:9] : '0, v[8:1], v[0],
           $sformatf("R%0d vec %0d", v[22:19], i));
    end
    // R7: event colliding with a read survives
    step(OP_WMASK, 8'h00, 8'h00, 8'h00, 1'b1, "R9 open mask");
    step(OP_EVT,   8'h00, 8'h01, 8'h00, 1'b0, "R2 evt0");
    step(OP_RSTAT, 8'h00, 8'h02, 8'h01, 1'b0, "R7 read with evt1");
    step(OP_RSTAT, 8'h00, 8'h00, 8'h02, 1'b1, "R7 next read");
    // R10: no strobe gives zero data while state is non-zero
    step(OP_EVT,   8'h00, 8'h08, 8'h00, 1'b0, "R10 evt3");
    @(negedge clk); #1 check("R10 idle rdata", rdata_o, 8'h00);
    step(OP_RMASK, 8'h00, 8'h00, 8'h00, 1'b0, "R10 mask addr");
    step(OP_RSTAT, 8'h00, 8'h00, 8'h08, 1'b1, "R10 status addr");
    // R1: reset mid-run
    step(OP_WMASK, 8'h0F, 8'h00, 8'h00, 1'b1, "R9 write 0F");
    step(OP_EVT,   8'h00, 8'h01, 8'h00, 1'b1, "R3 masked evt0");
    do_reset();
    step(OP_RMASK, 8'h00, 8'h00, 8'hFF, 1'b1, "R1 mask after reset");
    step(OP_WMASK, 8'h00, 8'h00, 8'h00, 1'b1, "R1 no held event");
    step(OP_RSTAT, 8'h00, 8'h00, 8'h00, 1'b1, "R1 status after reset");
    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end
endmodule